// File: doc/BRIEF.md
# Per-Thread Squash Walker with In-Order Retirement

This block keeps, for each hardware thread, an ordered queue of in-flight instruction sequence numbers. Each entry carries two flags: ready-to-commit and squashed. New entries join the young end of their thread's queue. Entries become ready either by a mark request that names their sequence number, or through a squash. They leave only from the old end of their own thread's queue.

A squash request names a thread and a sequence number. Every entry of that thread that is strictly younger than that number must be discarded. The block does not remove those entries at once. Starting in the cycle after the request, it walks the thread's queue from the youngest entry toward the oldest. In each cycle it flags at most `SQUASH_WIDTH` entries as both squashed and ready. Discarded work therefore drains through the same retire port as good work, and the retire port reports a squashed bit with each entry.

The block also reports, for each thread, whether the squash walk has finished and whether the queue head is ready. It also reports whether any active thread could commit.

Top module: `sqw_engine`

## Requirements
- R1: A squash request made while every thread's queue is empty is ignored. All squash-done flags stay 1, and no entry enqueued afterwards is found marked.
- R2: A squash request made while any queue holds an entry drives that thread's squash-done flag to 0 on the next cycle. This holds even if that thread's own queue is empty, in which case the flag returns to 1 one cycle later.
- R3: During a walk, each cycle flags at most `SQUASH_WIDTH` entries, youngest first. The done flag rises at the end of walk cycle max(1, ceil(N / SQUASH_WIDTH)), where N is the number of entries strictly younger than the squash number. Walk cycles start with the cycle after the request.
- R4: Every entry the walk flags becomes both squashed and ready to commit. No mark request is needed.
- R5: The walk stops at the first entry whose sequence number is less than or equal to the squash number. That entry, including an equal one, is left unflagged.
- R6: When the walk flags the thread's oldest entry, it completes in that same cycle.
- R7: The retire port offers only the head entry of the thread selected by `rt_tid`. `rt_valid` is 1 only when that queue is non-empty and its head is ready. Asserting `rt_ready` while `rt_valid` is 0 changes nothing.
- R8: `commit_possible` is 1 exactly when some thread whose `thread_active` bit is 1 has a non-empty queue with a ready head.
- R9: `rt_squashed` is 1 for an offered entry that a walk flagged and 0 for one that was made ready only by a mark request.
- R10: `enq_ready` is 0 for a thread whose squash-done flag is 0. It is also 0 in the cycle that a squash request names that thread.
- R11: A mark request sets ready only on live entries of the named thread whose sequence number equals `mark_seq`. Entries of other threads are unaffected.
- R12: `enq_ready` is 0 for a thread whose queue holds `LANE_DEPTH` entries, while other threads stay enqueueable.
- R13: After reset every queue is empty, all squash-done flags are 1, and no head is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| thread_active | input | NUM_THREADS | Threads that count toward commit_possible |
| enq_valid | input | 1 | Enqueue offer |
| enq_ready | output | 1 | Enqueue accepted this cycle when valid is also 1 |
| enq_tid | input | TID_W | Thread of the enqueued entry |
| enq_seq | input | SEQ_W | Sequence number of the enqueued entry |
| mark_valid | input | 1 | Mark-ready request |
| mark_tid | input | TID_W | Thread of the mark request |
| mark_seq | input | SEQ_W | Sequence number to mark ready |
| sq_req | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread to squash |
| sq_seq | input | SEQ_W | Entries strictly younger than this are squashed |
| rt_tid | input | TID_W | Thread whose head the retire port offers |
| rt_valid | output | 1 | Offered head is ready to retire |
| rt_ready | input | 1 | Consumer takes the offered head |
| rt_seq | output | SEQ_W | Sequence number of the offered head |
| rt_squashed | output | 1 | Offered head was discarded by a squash |
| head_ready | output | NUM_THREADS | Per-thread: queue non-empty and head ready |
| squash_done | output | NUM_THREADS | Per-thread: no squash walk in progress |
| commit_possible | output | 1 | Some active thread has a ready head |

Back-pressure rules. An entry is enqueued on a rising edge where both `enq_valid` and `enq_ready` are 1. `enq_ready` depends on `enq_tid` and `sq_req` but never on `enq_valid`. The retire handshake completes when both `rt_valid` and `rt_ready` are 1. `rt_valid` never depends on `rt_ready`.

## Verification
The two functions that can share a cycle are the squash walk and retirement from the same thread. The bench marks the oldest entry ready and issues a squash that leaves that entry untouched. It then asserts `rt_ready` in the first walk cycle, so the head leaves while the walker flags the youngest entries. It judges the outcome in three ways: the walk still finishes on the cycle counted from the number of younger entries; the retired head reports as not squashed; and the remaining queue drains with exactly the younger entries flagged squashed.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  typedef enum logic {
    LANE_IDLE = 1'b0,
    LANE_WALK = 1'b1
  } lane_state_e;
endpackage

// File: rtl/sqw_batch.sv
// One cycle of the squash walk: flags up to SQ_WIDTH entries from ptr downward.
module sqw_batch #(
  parameter int DEPTH    = 8,
  parameter int SEQ_W    = 16,
  parameter int SQ_WIDTH = 2,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                        en,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seqs,
  input  logic [IDX_W-1:0]            ptr,
  input  logic [CNT_W-1:0]            rem,
  input  logic [SEQ_W-1:0]            bound,
  output logic [DEPTH-1:0]            mark_mask,
  output logic                        fin,
  output logic [IDX_W-1:0]            ptr_nxt
);
  localparam logic [IDX_W-1:0] ONE_IDX = IDX_W'(1);
  localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

  logic [IDX_W-1:0] p;
  logic [CNT_W-1:0] r;
  logic             act;

  always_comb begin
    mark_mask = '0;
    p         = ptr;
    r         = rem;
    fin       = 1'b0;
    act       = en;
    if (en && r == '0) begin
      fin = 1'b1;
      act = 1'b0;
    end
    for (int i = 0; i < SQ_WIDTH; i++) begin
      if (act) begin
        if (seqs[p] > bound) begin
          mark_mask[p] = 1'b1;
          if (r == ONE_CNT) begin
            fin = 1'b1;
            act = 1'b0;
          end else begin
            p = p - ONE_IDX;
            r = r - ONE_CNT;
          end
        end else begin
          act = 1'b0;
        end
      end
    end
    if (en && !fin && !(seqs[p] > bound)) fin = 1'b1;
    ptr_nxt = p;
  end

  always_comb begin
    assert_batch_width_R3 : assert ($countones(mark_mask) <= SQ_WIDTH);
  end
endmodule

// File: rtl/sqw_lane.sv
// One thread's circular queue with its squash walker.
module sqw_lane
  import sqw_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int SEQ_W    = 16,
  parameter int SQ_WIDTH = 2,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_fire,
  input  logic [SEQ_W-1:0] enq_seq,
  input  logic             mark_fire,
  input  logic [SEQ_W-1:0] mark_seq,
  input  logic             ret_fire,
  input  logic             sq_start,
  input  logic [SEQ_W-1:0] sq_seq,
  output logic [SEQ_W-1:0] head_seq,
  output logic             head_rdy,
  output logic             head_sqd,
  output logic             lane_full,
  output logic             lane_empty,
  output logic             walk_done
);
  localparam logic [IDX_W-1:0] ONE_IDX = IDX_W'(1);

  logic [DEPTH-1:0][SEQ_W-1:0] seq_q;
  logic [DEPTH-1:0]            rdy_q, sqd_q, rdy_n, sqd_n, live;
  logic [IDX_W-1:0]            head_q, tail_q, ptr_q, ptr_nxt;
  logic [CNT_W-1:0]            cnt_q, rem;
  logic [SEQ_W-1:0]            bound_q;
  lane_state_e                 state_q;
  logic                        walk_en, fin;
  logic [DEPTH-1:0]            walk_mask;

  assign walk_en    = (state_q == LANE_WALK);
  assign lane_empty = (cnt_q == '0);
  assign lane_full  = (cnt_q == CNT_W'(DEPTH));
  assign walk_done  = !walk_en;
  assign head_seq   = seq_q[head_q];
  assign head_rdy   = !lane_empty && rdy_q[head_q];
  assign head_sqd   = sqd_q[head_q];
  assign rem        = lane_empty ? '0 : CNT_W'(ptr_q - head_q) + CNT_W'(1);

  for (genvar g = 0; g < DEPTH; g++) begin : g_live
    assign live[g] = CNT_W'(IDX_W'(g) - head_q) < cnt_q;
  end

  sqw_batch #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .SQ_WIDTH(SQ_WIDTH)) u_batch (
    .en(walk_en), .seqs(seq_q), .ptr(ptr_q), .rem(rem), .bound(bound_q),
    .mark_mask(walk_mask), .fin(fin), .ptr_nxt(ptr_nxt)
  );

  always_comb begin
    rdy_n = rdy_q | walk_mask;
    sqd_n = sqd_q | walk_mask;
    for (int i = 0; i < DEPTH; i++) begin
      if (mark_fire && live[i] && seq_q[i] == mark_seq) rdy_n[i] = 1'b1;
    end
    if (enq_fire) begin
      rdy_n[tail_q] = 1'b0;
      sqd_n[tail_q] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
      rdy_q   <= '0;
      sqd_q   <= '0;
      ptr_q   <= '0;
      bound_q <= '0;
      state_q <= LANE_IDLE;
    end else begin
      rdy_q <= rdy_n;
      sqd_q <= sqd_n;
      if (enq_fire) tail_q <= tail_q + ONE_IDX;
      if (ret_fire) head_q <= head_q + ONE_IDX;
      cnt_q <= cnt_q + CNT_W'(enq_fire) - CNT_W'(ret_fire);
      if (sq_start) begin
        state_q <= LANE_WALK;
        bound_q <= sq_seq;
        ptr_q   <= tail_q - ONE_IDX;
      end else if (walk_en) begin
        ptr_q <= ptr_nxt;
        if (fin) state_q <= LANE_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (enq_fire) seq_q[tail_q] <= enq_seq;
  end

  assert_retire_head_ready_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |-> (!lane_empty && rdy_q[head_q]));
  assert_no_overflow_R12 : assert property (@(posedge clk) disable iff (!rst_n)
    enq_fire |-> !lane_full);
  assert_enq_stall_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    walk_en |-> !enq_fire);
  assert_walk_marks_live_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    ((walk_mask & ~live) == '0));
endmodule

// File: rtl/sqw_head_mux.sv
// Retire-port selection and commit-possible reduction.
module sqw_head_mux #(
  parameter int NT     = 2,
  parameter int SEQ_W  = 16,
  localparam int TID_W = $clog2(NT)
) (
  input  logic [NT-1:0]            head_rdy,
  input  logic [NT-1:0][SEQ_W-1:0] head_seq,
  input  logic [NT-1:0]            head_sqd,
  input  logic [NT-1:0]            thread_active,
  input  logic [TID_W-1:0]         rt_tid,
  output logic                     rt_valid,
  output logic [SEQ_W-1:0]         rt_seq,
  output logic                     rt_squashed,
  output logic                     commit_possible
);
  assign rt_valid        = head_rdy[rt_tid];
  assign rt_seq          = head_seq[rt_tid];
  assign rt_squashed     = head_sqd[rt_tid];
  assign commit_possible = |(head_rdy & thread_active);
endmodule

// File: rtl/sqw_engine.sv
module sqw_engine #(
  parameter int NUM_THREADS  = 2,
  parameter int LANE_DEPTH   = 8,
  parameter int SEQ_W        = 16,
  parameter int SQUASH_WIDTH = 2,
  localparam int TID_W       = $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] thread_active,
  input  logic                   enq_valid,
  output logic                   enq_ready,
  input  logic [TID_W-1:0]       enq_tid,
  input  logic [SEQ_W-1:0]       enq_seq,
  input  logic                   mark_valid,
  input  logic [TID_W-1:0]       mark_tid,
  input  logic [SEQ_W-1:0]       mark_seq,
  input  logic                   sq_req,
  input  logic [TID_W-1:0]       sq_tid,
  input  logic [SEQ_W-1:0]       sq_seq,
  input  logic [TID_W-1:0]       rt_tid,
  output logic                   rt_valid,
  input  logic                   rt_ready,
  output logic [SEQ_W-1:0]       rt_seq,
  output logic                   rt_squashed,
  output logic [NUM_THREADS-1:0] head_ready,
  output logic [NUM_THREADS-1:0] squash_done,
  output logic                   commit_possible
);
  logic [NUM_THREADS-1:0]            lane_full, lane_empty, head_rdy, head_sqd;
  logic [NUM_THREADS-1:0][SEQ_W-1:0] head_seq;
  logic                              all_empty;

  assign all_empty = &lane_empty;
  assign enq_ready = !lane_full[enq_tid] && squash_done[enq_tid] &&
                     !(sq_req && sq_tid == enq_tid);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_lane
    logic enq_fire_t, mark_fire_t, ret_fire_t, sq_start_t;
    assign enq_fire_t  = enq_valid && enq_ready && enq_tid == TID_W'(t);
    assign mark_fire_t = mark_valid && mark_tid == TID_W'(t);
    assign ret_fire_t  = rt_valid && rt_ready && rt_tid == TID_W'(t);
    assign sq_start_t  = sq_req && !all_empty && sq_tid == TID_W'(t);

    sqw_lane #(.DEPTH(LANE_DEPTH), .SEQ_W(SEQ_W), .SQ_WIDTH(SQUASH_WIDTH)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .enq_fire(enq_fire_t), .enq_seq(enq_seq),
      .mark_fire(mark_fire_t), .mark_seq(mark_seq),
      .ret_fire(ret_fire_t),
      .sq_start(sq_start_t), .sq_seq(sq_seq),
      .head_seq(head_seq[t]), .head_rdy(head_rdy[t]), .head_sqd(head_sqd[t]),
      .lane_full(lane_full[t]), .lane_empty(lane_empty[t]),
      .walk_done(squash_done[t])
    );
  end

  sqw_head_mux #(.NT(NUM_THREADS), .SEQ_W(SEQ_W)) u_mux (
    .head_rdy(head_rdy), .head_seq(head_seq), .head_sqd(head_sqd),
    .thread_active(thread_active), .rt_tid(rt_tid),
    .rt_valid(rt_valid), .rt_seq(rt_seq), .rt_squashed(rt_squashed),
    .commit_possible(commit_possible)
  );

  assign head_ready = head_rdy;

  assert_empty_squash_ignored_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    (sq_req && all_empty) |=> (squash_done == '1));
  assert_squash_clears_done_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (sq_req && !all_empty) |=> !squash_done[$past(sq_tid)]);
  assert_retire_needs_ready_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid |-> head_ready[rt_tid]);
endmodule

// File: tb/sqw_engine_bench.sv
module sqw_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 2;
  localparam int DP = 8;
  localparam int SW = 16;

  localparam logic [2:0] OP_ENQ  = 3'd1;
  localparam logic [2:0] OP_MARK = 3'd2;
  localparam logic [2:0] OP_RET  = 3'd3;

  typedef struct packed {
    logic [2:0]  op;
    logic        tid;
    logic [15:0] seq;
    logic [1:0]  hr;
    logic [1:0]  dn;
    logic        cp;
    logic        rv;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    '{OP_ENQ,  1'b0, 16'd10, 2'b00, 2'b11, 1'b0, 1'b0},
    '{OP_ENQ,  1'b0, 16'd11, 2'b00, 2'b11, 1'b0, 1'b0},
    '{OP_ENQ,  1'b1, 16'd12, 2'b00, 2'b11, 1'b0, 1'b0},
    '{OP_MARK, 1'b1, 16'd12, 2'b10, 2'b11, 1'b1, 1'b0},
    '{OP_MARK, 1'b0, 16'd11, 2'b10, 2'b11, 1'b1, 1'b0},
    '{OP_MARK, 1'b0, 16'd10, 2'b11, 2'b11, 1'b1, 1'b0},
    '{OP_RET,  1'b0, 16'd10, 2'b11, 2'b11, 1'b1, 1'b1},
    '{OP_RET,  1'b1, 16'd12, 2'b01, 2'b11, 1'b1, 1'b1},
    '{OP_RET,  1'b0, 16'd11, 2'b00, 2'b11, 1'b0, 1'b1},
    '{OP_RET,  1'b0, 16'd0,  2'b00, 2'b11, 1'b0, 1'b0},
    '{OP_ENQ,  1'b1, 16'd20, 2'b00, 2'b11, 1'b0, 1'b0},
    '{OP_MARK, 1'b0, 16'd20, 2'b00, 2'b11, 1'b0, 1'b0},
    '{OP_MARK, 1'b1, 16'd20, 2'b10, 2'b11, 1'b1, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NT-1:0] thread_active;
  logic          enq_valid, enq_ready;
  logic          enq_tid;
  logic [SW-1:0] enq_seq;
  logic          mark_valid, mark_tid;
  logic [SW-1:0] mark_seq;
  logic          sq_req, sq_tid;
  logic [SW-1:0] sq_seq;
  logic          rt_tid, rt_valid, rt_ready, rt_squashed;
  logic [SW-1:0] rt_seq;
  logic [NT-1:0] head_ready, squash_done;
  logic          commit_possible;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sqw_engine #(.NUM_THREADS(NT), .LANE_DEPTH(DP), .SEQ_W(SW), .SQUASH_WIDTH(2)) u_sqw_engine (
    .clk(clk), .rst_n(rst_n), .thread_active(thread_active),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_tid(enq_tid), .enq_seq(enq_seq),
    .mark_valid(mark_valid), .mark_tid(mark_tid), .mark_seq(mark_seq),
    .sq_req(sq_req), .sq_tid(sq_tid), .sq_seq(sq_seq),
    .rt_tid(rt_tid), .rt_valid(rt_valid), .rt_ready(rt_ready),
    .rt_seq(rt_seq), .rt_squashed(rt_squashed),
    .head_ready(head_ready), .squash_done(squash_done), .commit_possible(commit_possible)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    enq_valid = 0; enq_tid = 0; enq_seq = '0;
    mark_valid = 0; mark_tid = 0; mark_seq = '0;
    sq_req = 0; sq_tid = 0; sq_seq = '0;
    rt_tid = 0; rt_ready = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    idle_inputs();
    thread_active = '1;
    rst_n = 0;
    step(); step();
    rst_n = 1;
    step();
  endtask

  task automatic do_enq(logic t, logic [SW-1:0] s);
    enq_valid = 1; enq_tid = t; enq_seq = s;
    step();
    idle_inputs();
  endtask

  task automatic do_mark(logic t, logic [SW-1:0] s);
    mark_valid = 1; mark_tid = t; mark_seq = s;
    step();
    idle_inputs();
  endtask

  task automatic do_ret(logic t, logic [SW-1:0] s, logic sqd, string req);
    rt_tid = t;
    #1;
    check({req, " rt_valid"}, 32'(rt_valid), 32'd1);
    check({req, " rt_seq"}, 32'(rt_seq), 32'(s));
    check({"R9 rt_squashed ", req}, 32'(rt_squashed), 32'(sqd));
    rt_ready = 1;
    step();
    idle_inputs();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fails++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    do_reset();
    // R13 reset state
    check("R13 head_ready after reset", 32'(head_ready), 32'd0);
    check("R13 squash_done after reset", 32'(squash_done), 32'd3);
    check("R13 commit_possible after reset", 32'(commit_possible), 32'd0);

    // Vector table: enqueue, mark, retire flow (R7 R8 R11)
    for (int v = 0; v < NVEC; v++) begin
      case (VEC[v].op)
        OP_ENQ: begin
          enq_valid = 1; enq_tid = VEC[v].tid; enq_seq = VEC[v].seq;
        end
        OP_MARK: begin
          mark_valid = 1; mark_tid = VEC[v].tid; mark_seq = VEC[v].seq;
        end
        OP_RET: begin
          rt_tid = VEC[v].tid; rt_ready = 1;
          #1;
          check($sformatf("R7 vec%0d rt_valid", v), 32'(rt_valid), 32'(VEC[v].rv));
          if (VEC[v].rv)
            check($sformatf("R7 vec%0d rt_seq", v), 32'(rt_seq), 32'(VEC[v].seq));
        end
        default: ;
      endcase
      step();
      idle_inputs();
      check($sformatf("R11 vec%0d head_ready", v), 32'(head_ready), 32'(VEC[v].hr));
      check($sformatf("R2 vec%0d squash_done", v), 32'(squash_done), 32'(VEC[v].dn));
      check($sformatf("R8 vec%0d commit_possible", v), 32'(commit_possible), 32'(VEC[v].cp));
    end

    // R8: inactive thread does not count
    thread_active = 2'b01;
    #1;
    check("R8 inactive thread masks commit_possible", 32'(commit_possible), 32'd0);
    thread_active = 2'b11;
    #1;
    check("R8 active thread restores commit_possible", 32'(commit_possible), 32'd1);

    // R1: squash on fully empty buffer
    do_reset();
    sq_req = 1; sq_tid = 0; sq_seq = 16'd0;
    step();
    idle_inputs();
    check("R1 done flags after empty squash", 32'(squash_done), 32'd3);
    step();
    check("R1 done flags one cycle later", 32'(squash_done), 32'd3);
    do_enq(0, 16'd5);
    check("R1 new entry not marked", 32'(head_ready), 32'd0);

    // R2 R3 R5 R10 with retire overlapping the walk
    do_reset();
    for (int k = 0; k < 7; k++) do_enq(0, 16'(30 + k));
    do_mark(0, 16'd30);
    sq_req = 1; sq_tid = 0; sq_seq = 16'd31;
    enq_valid = 0; enq_tid = 0;
    #1;
    check("R10 enq_ready low in request cycle", 32'(enq_ready), 32'd0);
    step();
    idle_inputs();
    check("R2 done low after request", 32'(squash_done[0]), 32'd0);
    enq_tid = 0;
    #1;
    check("R10 enq_ready low while walking", 32'(enq_ready), 32'd0);
    enq_tid = 1;
    #1;
    check("R10 other thread still enqueueable", 32'(enq_ready), 32'd1);
    // walk cycle 1 coincides with retiring the head (seq 30)
    do_ret(0, 16'd30, 1'b0, "R7 retire during walk");
    check("R3 done low after walk cycle 1", 32'(squash_done[0]), 32'd0);
    step();
    check("R3 done low after walk cycle 2", 32'(squash_done[0]), 32'd0);
    step();
    check("R3 done high after walk cycle 3", 32'(squash_done[0]), 32'd1);
    check("R5 equal entry left unmarked", 32'(head_ready[0]), 32'd0);
    do_mark(0, 16'd31);
    do_ret(0, 16'd31, 1'b0, "R5 kept entry");
    for (int k = 32; k <= 36; k++) do_ret(0, 16'(k), 1'b1, "R4 flagged entry");
    check("R4 queue drained", 32'(head_ready[0]), 32'd0);

    // R6: walk reaches the oldest entry
    do_enq(1, 16'd40); do_enq(1, 16'd41); do_enq(1, 16'd42);
    sq_req = 1; sq_tid = 1; sq_seq = 16'd5;
    step();
    idle_inputs();
    step();
    check("R6 done low after walk cycle 1", 32'(squash_done[1]), 32'd0);
    step();
    check("R6 done high once oldest flagged", 32'(squash_done[1]), 32'd1);
    check("R6 oldest entry ready", 32'(head_ready[1]), 32'd1);
    for (int k = 40; k <= 42; k++) do_ret(1, 16'(k), 1'b1, "R6 flagged entry");

    // R3/R5: nothing younger, one walk cycle
    do_enq(1, 16'd50);
    sq_req = 1; sq_tid = 1; sq_seq = 16'd50;
    step();
    idle_inputs();
    check("R2 done low for equal-only squash", 32'(squash_done[1]), 32'd0);
    step();
    check("R3 done after single walk cycle", 32'(squash_done[1]), 32'd1);
    check("R5 equal entry not flagged", 32'(head_ready[1]), 32'd0);

    // R2: squash on empty thread while other thread holds an entry
    sq_req = 1; sq_tid = 0; sq_seq = 16'd0;
    step();
    idle_inputs();
    check("R2 empty-thread squash drops done", 32'(squash_done[0]), 32'd0);
    step();
    check("R2 empty-thread squash completes", 32'(squash_done[0]), 32'd1);

    // R7: rt_ready without rt_valid has no effect
    rt_tid = 1; rt_ready = 1;
    #1;
    check("R7 rt_valid low on unready head", 32'(rt_valid), 32'd0);
    step();
    idle_inputs();
    do_mark(1, 16'd50);
    do_ret(1, 16'd50, 1'b0, "R7 head kept after ignored ready");

    // R12: full queue back-pressure
    do_reset();
    for (int k = 0; k < DP; k++) do_enq(0, 16'(100 + k));
    enq_tid = 0;
    #1;
    check("R12 enq_ready low when full", 32'(enq_ready), 32'd0);
    enq_tid = 1;
    #1;
    check("R12 other thread not blocked", 32'(enq_ready), 32'd1);
    enq_valid = 1; enq_tid = 0; enq_seq = 16'd200;
    step();
    idle_inputs();
    do_mark(0, 16'd100);
    do_ret(0, 16'd100, 1'b0, "R12 head intact after refused enqueue");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule